// File: doc/BRIEF.md
# Address-Strobed Function Decoder with Wait Generator

This block sits on the local 8-bit bus of a board-level processor. Commands are carried by the address bus rather than the data bus. When the processor starts an access to the board control port, each set address bit in a fixed group becomes a one-clock function strobe. These strobes step the drive head, clear the board timer, start the board timer, or clear the interrupt pending toward the host. Several bits may be set in one access, and each then fires its own strobe in the same cycle.

A read of the board status port with the wait bit of the address set holds the processor with a wait request. The wait lasts until the disk formatter raises its data request or its interrupt. This paces byte transfers to the formatter without a software polling loop.

The block also holds a host interrupt latch. An external request line sets it, the clear strobe resets it, and its state is brought out as a status bit.

Top module: `fn_port_decoder`

## Requirements
- R1: A synchronous active-low reset drives all four strobes, the wait output and the host interrupt bit low on the next clock edge.
- R2: An access to the control port is `ctl_sel` high together with `io_rd` or `io_wr`. On the first clock edge of such an access, address bit 3 produces `step_stb`. The strobe is high for exactly the one cycle after that edge.
- R3: On the same edge and with the same timing as R2, address bit 4 produces `tmr_clr_stb` and address bit 6 produces `tmr_go_stb`.
- R4: On the same edge and with the same timing as R2, address bit 5 produces `hint_clr_stb`.
- R5: When several of address bits 3 to 6 are set in one access, every matching strobe goes high in the same cycle.
- R6: An access held over several cycles fires its strobes only once. Address changes during the held access produce no further strobes.
- R7: Address bit 7 on a control port access produces no strobe and no wait. Address bits with `ctl_sel` low produce no strobe.
- R8: A status read is `sts_sel` and `io_rd` high with address bit 7 set. If `fmt_drq` and `fmt_irq` are both low at its first clock edge, `wait_req` goes high after that edge.
- R9: `wait_req` goes low after the first edge at which `fmt_drq` or `fmt_irq` is sampled high. If either is high at the first edge of the read, no wait is inserted. A read still held after its release is not stalled again.
- R10: A status read with address bit 7 clear, or a status port write, never raises `wait_req`.
- R11: `host_int` goes high after an edge at which `host_req` is sampled high. It goes low after an edge at which `hint_clr_stb` is high and `host_req` is low. A request in the same cycle as the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 8 | Processor address bits 7..0 |
| io_rd | input | 1 | I/O read qualifier |
| io_wr | input | 1 | I/O write qualifier |
| ctl_sel | input | 1 | Control port selected |
| sts_sel | input | 1 | Status port selected |
| fmt_drq | input | 1 | Formatter data request |
| fmt_irq | input | 1 | Formatter interrupt |
| host_req | input | 1 | Request that sets the host interrupt latch |
| step_stb | output | 1 | Head step strobe (address bit 3) |
| tmr_clr_stb | output | 1 | Timer clear strobe (address bit 4) |
| hint_clr_stb | output | 1 | Host interrupt clear strobe (address bit 5) |
| tmr_go_stb | output | 1 | Timer start strobe (address bit 6) |
| wait_req | output | 1 | Processor wait request |
| host_int | output | 1 | Host interrupt latch state |

## Verification
The strobes and `wait_req` each change one clock edge after the first edge of an access. The wait release comes one edge after the data request or interrupt is sampled. The host interrupt bit follows its request by one edge, and follows a clear access by two edges, since the clear strobe it waits on is itself registered. The bench drives inputs right after a falling edge and compares every output at the next falling edge against a cycle model advanced on the rising edge, so each result is compared in exactly the cycle it is due.

// File: rtl/fn_port_pkg.sv
// Package: shared indices and constants for the address-strobed function decoder.
// Assumes: function strobes are packed LSB-first from the lowest function address bit.
package fn_port_pkg;
    // Number of address-decoded function strobes
    localparam int N_FN     = 4;
    // Strobe vector slot for each function, ordered by address bit
    localparam int FN_STEP  = 0;   // address bit FN_LSB + 0
    localparam int FN_TCLR  = 1;   // address bit FN_LSB + 1
    localparam int FN_HCLR  = 2;   // address bit FN_LSB + 2
    localparam int FN_TGO   = 3;   // address bit FN_LSB + 3

    // Kind of bus cycle an access detector qualifies
    typedef enum logic [1:0] {
        ACC_RD_ONLY = 2'b01,
        ACC_WR_ONLY = 2'b10,
        ACC_RD_WR   = 2'b11
    } acc_kind_e;
endpackage

// File: rtl/port_access_edge.sv
// Module: port_access_edge
// Detects the start of an I/O access to one port. The access is the port select,
// an extra qualifier and an allowed bus cycle kind, all high together. 'first' is
// high combinationally in the first cycle of an access, so a consumer that
// registers it reacts once per access.
// Assumes: inputs are synchronous to clk.
module port_access_edge
    import fn_port_pkg::*;
#(
    parameter acc_kind_e KIND = ACC_RD_WR
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic qual,
    input  logic rd,
    input  logic wr,
    output logic active,
    output logic first
);
    logic cyc_ok;
    logic active_q;

    // Select which bus cycle kinds count for this port
    generate
        if (KIND == ACC_RD_ONLY) begin : g_rd
            assign cyc_ok = rd;
        end else if (KIND == ACC_WR_ONLY) begin : g_wr
            assign cyc_ok = wr;
        end else begin : g_rw
            assign cyc_ok = rd | wr;
        end
    endgenerate

    // Qualified access presence
    always_comb begin
        active = sel & qual & cyc_ok;
    end

    // Remember the access state of the previous cycle
    always_ff @(posedge clk) begin
        if (!rst_n) active_q <= 1'b0;
        else        active_q <= active;
    end

    // First cycle of the access
    always_comb begin
        first = active & ~active_q;
    end
endmodule

// File: rtl/fn_strobe_bank.sv
// Module: fn_strobe_bank
// Turns a group of address bits into registered one-clock strobes. Each strobe
// fires when 'fire' is high and its own address bit is set.
// Assumes: 'fire' is high for at most one cycle per access.
module fn_strobe_bank #(
    parameter int ADDR_W = 8,
    parameter int FN_LSB = 3,
    parameter int N_FN   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [ADDR_W-1:0] addr,
    output logic [N_FN-1:0]   stb
);
    localparam int FN_MSB = FN_LSB + N_FN - 1;

    // One register per function bit
    generate
        for (genvar i = 0; i < N_FN; i++) begin : g_fn
            // Capture the strobe for this function bit
            always_ff @(posedge clk) begin
                if (!rst_n) stb[i] <= 1'b0;
                else        stb[i] <= fire & addr[FN_LSB + i];
            end
        end
    endgenerate

    // The function field must fit in the address bus
    initial begin
        if (FN_MSB >= ADDR_W) $error("function field exceeds address width");
    end
endmodule

// File: rtl/wait_gen.sv
// Module: wait_gen
// Holds the processor in a wait while a status read is pending and the
// formatter has not yet raised its data request or interrupt.
// Assumes: the read stays active while the processor is held. A read that
// ends also ends its wait.
module wait_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_active,
    input  logic rd_first,
    input  logic drq,
    input  logic irq,
    output logic wait_o
);
    logic ready;
    logic wait_d;

    // Formatter has something for the processor
    always_comb begin
        ready = drq | irq;
    end

    // Arm on the first read cycle, hold until ready or the read ends
    always_comb begin
        wait_d = rd_active & ~ready & (rd_first | wait_o);
    end

    // Wait output register
    always_ff @(posedge clk) begin
        if (!rst_n) wait_o <= 1'b0;
        else        wait_o <= wait_d;
    end
endmodule

// File: rtl/host_int_latch.sv
// Module: host_int_latch
// Pending interrupt toward the host. Set by a request, cleared by a strobe.
// A set and a clear in the same cycle leave it set, so no request is lost.
// Assumes: inputs are synchronous to clk.
module host_int_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend
);
    // Latch update with set priority
    always_ff @(posedge clk) begin
        if (!rst_n)     pend <= 1'b0;
        else if (set_i) pend <= 1'b1;
        else if (clr_i) pend <= 1'b0;
    end
endmodule

// File: rtl/fn_port_decoder.sv
// Module: fn_port_decoder (top)
// Decodes control-port accesses into address-carried function strobes.
// Stalls status-port reads that carry the wait bit until the formatter is ready.
// Keeps the host interrupt latch.
// Assumes: all inputs are synchronous to clk. The reset is synchronous, active low.
module fn_port_decoder
    import fn_port_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int FN_LSB   = 3,
    parameter int WAIT_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic              ctl_sel,
    input  logic              sts_sel,
    input  logic              fmt_drq,
    input  logic              fmt_irq,
    input  logic              host_req,
    output logic              step_stb,
    output logic              tmr_clr_stb,
    output logic              hint_clr_stb,
    output logic              tmr_go_stb,
    output logic              wait_req,
    output logic              host_int
);
    logic            ctl_active, ctl_first;
    logic            sts_active, sts_first;
    logic [N_FN-1:0] fn_stb;

    // Control port: any read or write starts a function access
    port_access_edge #(.KIND(ACC_RD_WR)) u_ctl_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (ctl_sel),
        .qual   (1'b1),
        .rd     (io_rd),
        .wr     (io_wr),
        .active (ctl_active),
        .first  (ctl_first)
    );

    // Status port: only a read with the wait bit set is a wait candidate
    port_access_edge #(.KIND(ACC_RD_ONLY)) u_sts_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (sts_sel),
        .qual   (addr[WAIT_BIT]),
        .rd     (io_rd),
        .wr     (io_wr),
        .active (sts_active),
        .first  (sts_first)
    );

    fn_strobe_bank #(
        .ADDR_W (ADDR_W),
        .FN_LSB (FN_LSB),
        .N_FN   (N_FN)
    ) u_strobes (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (ctl_first),
        .addr  (addr),
        .stb   (fn_stb)
    );

    wait_gen u_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_active (sts_active),
        .rd_first  (sts_first),
        .drq       (fmt_drq),
        .irq       (fmt_irq),
        .wait_o    (wait_req)
    );

    host_int_latch u_hint (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (host_req),
        .clr_i (fn_stb[FN_HCLR]),
        .pend  (host_int)
    );

    // Map strobe slots to named outputs
    always_comb begin
        step_stb     = fn_stb[FN_STEP];
        tmr_clr_stb  = fn_stb[FN_TCLR];
        hint_clr_stb = fn_stb[FN_HCLR];
        tmr_go_stb   = fn_stb[FN_TGO];
    end

    // Wait bit must not overlap the function field
    initial begin
        if (WAIT_BIT >= FN_LSB && WAIT_BIT < FN_LSB + N_FN)
            $error("wait bit overlaps the function field");
    end
endmodule

// File: rtl/fn_port_decoder_chk.sv
// Module: fn_port_decoder_chk
// Port-level temporal checks on fn_port_decoder, attached with bind.
module fn_port_decoder_chk #(
    parameter int ADDR_W   = 8,
    parameter int FN_LSB   = 3,
    parameter int WAIT_BIT = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              io_rd,
    input logic              io_wr,
    input logic              ctl_sel,
    input logic              sts_sel,
    input logic              fmt_drq,
    input logic              fmt_irq,
    input logic              host_req,
    input logic              step_stb,
    input logic              tmr_clr_stb,
    input logic              hint_clr_stb,
    input logic              tmr_go_stb,
    input logic              wait_req,
    input logic              host_int
);
    logic ctl_acc;
    logic sts_rd;

    // Bus-level view of the two port accesses
    always_comb begin
        ctl_acc = ctl_sel & (io_rd | io_wr);
        sts_rd  = sts_sel & io_rd & addr[WAIT_BIT];
    end

    // R2
    step_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_stb |=> !step_stb);

    // R2
    step_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_stb |-> $past(ctl_acc && addr[FN_LSB]));

    // R3
    tmr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_clr_stb || tmr_go_stb) |-> $past(ctl_acc));

    // R4
    hclr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hint_clr_stb |-> $past(ctl_acc && addr[FN_LSB + 2]));

    // R8
    wait_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wait_req |-> $past(sts_rd));

    // R9
    wait_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_drq || fmt_irq) |=> !wait_req);

    // R11
    hint_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_req |=> host_int);

    // R11
    hint_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hint_clr_stb && !host_req) |=> !host_int);
endmodule

bind fn_port_decoder fn_port_decoder_chk #(
    .ADDR_W   (ADDR_W),
    .FN_LSB   (FN_LSB),
    .WAIT_BIT (WAIT_BIT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr         (addr),
    .io_rd        (io_rd),
    .io_wr        (io_wr),
    .ctl_sel      (ctl_sel),
    .sts_sel      (sts_sel),
    .fmt_drq      (fmt_drq),
    .fmt_irq      (fmt_irq),
    .host_req     (host_req),
    .step_stb     (step_stb),
    .tmr_clr_stb  (tmr_clr_stb),
    .hint_clr_stb (hint_clr_stb),
    .tmr_go_stb   (tmr_go_stb),
    .wait_req     (wait_req),
    .host_int     (host_int)
);

// File: tb/fn_port_decoder_test.sv
// Bench for fn_port_decoder: directed corner cases plus seeded random bus traffic,
// compared every cycle against a cycle model built from the requirements.
module fn_port_decoder_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] addr;
    logic       io_rd, io_wr, ctl_sel, sts_sel, fmt_drq, fmt_irq, host_req;
    logic       step_stb, tmr_clr_stb, hint_clr_stb, tmr_go_stb, wait_req, host_int;

    int vectors = 0;
    int fails   = 0;

    // 50 MHz clock
    always #10 clk = ~clk;

    fn_port_decoder uut (
        .clk (clk), .rst_n (rst_n), .addr (addr), .io_rd (io_rd), .io_wr (io_wr),
        .ctl_sel (ctl_sel), .sts_sel (sts_sel), .fmt_drq (fmt_drq), .fmt_irq (fmt_irq),
        .host_req (host_req), .step_stb (step_stb), .tmr_clr_stb (tmr_clr_stb),
        .hint_clr_stb (hint_clr_stb), .tmr_go_stb (tmr_go_stb), .wait_req (wait_req),
        .host_int (host_int)
    );

    // Reference cycle model state
    logic       m_ctl_q, m_sts_q, m_wait, m_hint;
    logic [3:0] m_stb;

    function automatic logic ctl_access(input logic s, r, w);
        return s & (r | w);
    endfunction

    function automatic logic sts_access(input logic s, r, input logic [7:0] a);
        return s & r & a[7];
    endfunction

    // Advance the model on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctl_q <= 1'b0; m_sts_q <= 1'b0; m_wait <= 1'b0; m_hint <= 1'b0; m_stb <= '0;
        end else begin
            m_ctl_q <= ctl_access(ctl_sel, io_rd, io_wr);
            m_sts_q <= sts_access(sts_sel, io_rd, addr);
            m_stb   <= (ctl_access(ctl_sel, io_rd, io_wr) && !m_ctl_q) ? addr[6:3] : 4'b0;
            m_wait  <= sts_access(sts_sel, io_rd, addr) && !(fmt_drq || fmt_irq)
                       && (m_wait || !m_sts_q);
            m_hint  <= host_req ? 1'b1 : (m_stb[2] ? 1'b0 : m_hint);
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against the model; ctx names the scenario requirement
    task automatic check_all(input string ctx);
        chk(step_stb,     m_stb[0], {ctx, "/R2 step_stb"});
        chk(tmr_clr_stb,  m_stb[1], {ctx, "/R3 tmr_clr_stb"});
        chk(hint_clr_stb, m_stb[2], {ctx, "/R4 hint_clr_stb"});
        chk(tmr_go_stb,   m_stb[3], {ctx, "/R3 tmr_go_stb"});
        chk(wait_req,     m_wait,   {ctx, "/R8 wait_req"});
        chk(host_int,     m_hint,   {ctx, "/R11 host_int"});
    endtask

    // Drive one cycle of inputs after a falling edge, check at the next one
    task automatic cyc(input logic cs, ss, rd, wr, input logic [7:0] a,
                       input logic drq, irq, hr, input string ctx);
        ctl_sel = cs; sts_sel = ss; io_rd = rd; io_wr = wr; addr = a;
        fmt_drq = drq; fmt_irq = irq; host_req = hr;
        @(negedge clk);
        check_all(ctx);
    endtask

    task automatic idle(input string ctx);
        cyc(0, 0, 0, 0, 8'h00, 0, 0, 0, ctx);
    endtask

    // Watchdog: a hung run is a failure and still prints the summary
    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20517));
        rst_n = 1'b0;
        ctl_sel = 0; sts_sel = 0; io_rd = 0; io_wr = 0; addr = '0;
        fmt_drq = 0; fmt_irq = 0; host_req = 0;
        @(negedge clk); @(negedge clk);
        // R1: reset state, explicit
        chk(step_stb | tmr_clr_stb | hint_clr_stb | tmr_go_stb, 1'b0, "R1 strobes");
        chk(wait_req, 1'b0, "R1 wait_req");
        chk(host_int, 1'b0, "R1 host_int");
        rst_n = 1'b1;
        idle("R1");

        // R2: single step strobe on a control write, one cycle only
        cyc(1, 0, 0, 1, 8'h08, 0, 0, 0, "R2");
        chk(step_stb, 1'b1, "R2 step high");
        idle("R2");
        chk(step_stb, 1'b0, "R2 step low");
        // R3: timer clear and start via a control read
        cyc(1, 0, 1, 0, 8'h50, 0, 0, 0, "R3");
        chk(tmr_clr_stb & tmr_go_stb, 1'b1, "R3 timer strobes");
        idle("R3");
        // R5: all four functions at once
        cyc(1, 0, 0, 1, 8'h78, 0, 0, 0, "R5");
        chk(step_stb & tmr_clr_stb & hint_clr_stb & tmr_go_stb, 1'b1, "R5 all strobes");
        idle("R5");
        // R6: held access with changing address fires once
        cyc(1, 0, 0, 1, 8'h08, 0, 0, 0, "R6");
        cyc(1, 0, 0, 1, 8'h70, 0, 0, 0, "R6");
        chk(tmr_clr_stb | tmr_go_stb | step_stb, 1'b0, "R6 no re-fire");
        cyc(1, 0, 0, 1, 8'h78, 0, 0, 0, "R6");
        idle("R6");
        // R7: wait bit on control port, and bits without select
        cyc(1, 0, 1, 0, 8'h80, 0, 0, 0, "R7");
        chk(step_stb | tmr_clr_stb | hint_clr_stb | tmr_go_stb | wait_req, 1'b0, "R7 bit7 ctl");
        idle("R7");
        cyc(0, 0, 0, 1, 8'h78, 0, 0, 0, "R7");
        chk(step_stb | tmr_clr_stb | hint_clr_stb | tmr_go_stb, 1'b0, "R7 no select");
        idle("R7");
        // R8/R9: wait held, released by irq, no re-stall while read held
        cyc(0, 1, 1, 0, 8'h80, 0, 0, 0, "R8");
        chk(wait_req, 1'b1, "R8 wait set");
        cyc(0, 1, 1, 0, 8'h80, 0, 0, 0, "R8");
        chk(wait_req, 1'b1, "R8 wait held");
        cyc(0, 1, 1, 0, 8'h80, 0, 1, 0, "R9");
        chk(wait_req, 1'b0, "R9 release");
        cyc(0, 1, 1, 0, 8'h80, 0, 0, 0, "R9");
        chk(wait_req, 1'b0, "R9 no re-stall");
        idle("R9");
        // R9: drq already high at read start
        cyc(0, 1, 1, 0, 8'h80, 1, 0, 0, "R9");
        chk(wait_req, 1'b0, "R9 ready at start");
        idle("R9");
        // R10: status read without wait bit, status write with it
        cyc(0, 1, 1, 0, 8'h7F, 0, 0, 0, "R10");
        chk(wait_req, 1'b0, "R10 no bit7");
        idle("R10");
        cyc(0, 1, 0, 1, 8'h80, 0, 0, 0, "R10");
        chk(wait_req, 1'b0, "R10 write");
        idle("R10");
        // R11: set, clear, and set winning over clear
        cyc(0, 0, 0, 0, 8'h00, 0, 0, 1, "R11");
        chk(host_int, 1'b1, "R11 set");
        cyc(1, 0, 0, 1, 8'h20, 0, 0, 0, "R11");
        chk(host_int, 1'b1, "R11 still set with strobe");
        idle("R11");
        chk(host_int, 1'b0, "R11 cleared");
        cyc(0, 0, 0, 0, 8'h00, 0, 0, 1, "R11");
        cyc(1, 0, 0, 1, 8'h20, 0, 0, 0, "R11");
        cyc(0, 0, 0, 0, 8'h00, 0, 0, 1, "R11");
        chk(host_int, 1'b1, "R11 set wins");
        idle("R11");
        // R1: reset mid-activity
        cyc(0, 1, 1, 0, 8'h80, 0, 0, 0, "R1");
        rst_n = 1'b0;
        idle("R1");
        chk(wait_req | host_int, 1'b0, "R1 reset clears");
        rst_n = 1'b1;

        // Seeded random traffic with held input patterns
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom();
            if (r[2:0] == 3'd0) begin
                ctl_sel = r[3]; sts_sel = r[4]; io_rd = r[5]; io_wr = r[6];
                addr = r[14:7];
            end
            fmt_drq  = (r[19:16] == 4'd0);
            fmt_irq  = (r[23:20] == 4'd0);
            host_req = (r[28:24] == 5'd0);
            rst_n    = (r[31:29] != 3'd0) || (i % 97 != 0);
            @(negedge clk);
            check_all("R5");
        end
        rst_n = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule